// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block sits between the PWM comparator of a synchronous step-down regulator and its two gate drivers. A PWM request of 1 asks for the high-side switch and 0 asks for the low-side switch. The block turns the request into two gate commands that are never high together. Dead time adapts to the hardware: a switch is commanded on only after the feedback flag from the opposite driver reports that gate off. No fixed delay is used. The request may stay high or low for any number of switching periods, so the duty cycle can be anything from 0% to 100%.

The controller has six named states:

- `ST_IDLE`: disabled, both gates off.
- `ST_HI_WAIT`: high side requested, waiting for the low side to be confirmed off.
- `ST_HI_ON`: high-side gate commanded on.
- `ST_LO_WAIT`: low side requested, waiting for the high side to be confirmed off.
- `ST_LO_ON`: low-side gate commanded on.
- `ST_FAULT`: off-confirmation timeout; both gates off.

The transitions are:

- **Start:** `ST_IDLE` goes to `ST_HI_WAIT` or `ST_LO_WAIT` when enabled, chosen by the request.
- **Confirm:** a wait state goes to its ON state when the opposite feedback flag is sampled high.
- **Reversal:** a wait state goes to the other wait state when the request flips.
- **Switch-off:** an ON state goes to the opposite wait state when the request flips.
- **Timeout:** a wait state goes to `ST_FAULT` after too long without feedback.
- **Disable:** any state goes to `ST_IDLE` when `enable` is low. This is the only exit from `ST_FAULT`.

Gate and fault outputs are registered, decoded from the next state. They therefore change on the clock edge that moves the state.

Top module: `adaptive_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `hs_gate`, `ls_gate` and `fault` are 0.
- R2: If `enable` is sampled 0 at a rising edge, then after that edge both gates and `fault` are 0. This holds from any state, including the fault state.
- R3: A gate that is on goes low on the first edge at which the request is sampled at the opposite value (`pwm_req`=0 for `hs_gate`, 1 for `ls_gate`).
- R4: `hs_gate` rises only on an edge at which `enable`=1, `pwm_req`=1 and `ls_off_fb`=1 are sampled while waiting for the high side. It rises on the first such edge.
- R5: `ls_gate` rises only on an edge at which `enable`=1, `pwm_req`=0 and `hs_off_fb`=1 are sampled while waiting for the low side. It rises on the first such edge.
- R6: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R7: While `enable`=1 and `pwm_req`=1 are held, `hs_gate` stays 1 indefinitely once on (100% duty); the timeout never applies to an ON state.
- R8: If the request flips while a gate is still waiting to turn on, the block returns to waiting for the other gate. That gate again turns on only under its own feedback rule (R4/R5).
- R9: A wait state whose feedback flag is 0 for `off_timeout`+1 consecutive cycles moves to fault at the next edge. In fault, `fault`=1 and both gates are 0 until `enable` is sampled 0.
- R10: The timeout count restarts from zero whenever the block enters a wait state, including on a reversal between the two wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = run, 0 = hold both gates off and clear fault |
| pwm_req | input | 1 | 1 = high side wanted, 0 = low side wanted |
| hs_off_fb | input | 1 | 1 = high-side gate observed below its off level |
| ls_off_fb | input | 1 | 1 = low-side gate observed below its off level |
| off_timeout | input | TMO_W | Timeout limit in cycles for a wait state (see R9) |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| fault | output | 1 | Off-confirmation timeout flag |

## Verification
The hardest case to reach is a chain of reversals that stays entirely inside the two wait states with neither feedback flag ever asserting. Only this case separates a timer that restarts on each reversal from one that keeps counting. The bench forces both feedback models stuck off and flips the request every third cycle against a small limit. It then holds the request to let the limit expire. Random phases with a feedback delay longer than the request run length also produce frequent back-and-forth reversals before any gate turns on.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HI_WAIT = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_LO_WAIT = 3'd3,
        ST_LO_ON   = 3'd4,
        ST_FAULT   = 3'd5
    } agc_state_e;

    function automatic logic is_wait(agc_state_e s);
        return (s == ST_HI_WAIT) || (s == ST_LO_WAIT);
    endfunction

endpackage

// File: rtl/agc_offconf_timer.sv
module agc_offconf_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         waiting,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Counts cycles spent in one wait state; cleared on any state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!waiting || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign expired = waiting && (cnt_q == limit);

endmodule

// File: rtl/agc_fsm.sv
module agc_fsm
    import agc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       pwm_req,
    input  logic       hs_off_fb,
    input  logic       ls_off_fb,
    input  logic       tmo_hit,
    output agc_state_e state_q,
    output agc_state_e state_d,
    output logic       hs_cmd,
    output logic       ls_cmd,
    output logic       fault_flag
);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = pwm_req ? ST_HI_WAIT : ST_LO_WAIT;
                ST_HI_WAIT: begin
                    if (!pwm_req)       state_d = ST_LO_WAIT;
                    else if (ls_off_fb) state_d = ST_HI_ON;
                    else if (tmo_hit)   state_d = ST_FAULT;
                end
                ST_HI_ON:   if (!pwm_req) state_d = ST_LO_WAIT;
                ST_LO_WAIT: begin
                    if (pwm_req)        state_d = ST_HI_WAIT;
                    else if (hs_off_fb) state_d = ST_LO_ON;
                    else if (tmo_hit)   state_d = ST_FAULT;
                end
                ST_LO_ON:   if (pwm_req) state_d = ST_HI_WAIT;
                ST_FAULT:   state_d = ST_FAULT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cmd     <= 1'b0;
            ls_cmd     <= 1'b0;
            fault_flag <= 1'b0;
        end else begin
            hs_cmd     <= (state_d == ST_HI_ON);
            ls_cmd     <= (state_d == ST_LO_ON);
            fault_flag <= (state_d == ST_FAULT);
        end
    end

endmodule

// File: rtl/adaptive_gate_ctrl.sv
module adaptive_gate_ctrl
    import agc_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pwm_req,
    input  logic             hs_off_fb,
    input  logic             ls_off_fb,
    input  logic [TMO_W-1:0] off_timeout,
    output logic             hs_gate,
    output logic             ls_gate,
    output logic             fault
);

    agc_state_e state_q;
    agc_state_e state_d;
    logic       tmo_hit;
    logic       waiting;
    logic       restart;

    assign waiting = is_wait(state_q);
    assign restart = (state_d != state_q);

    agc_offconf_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .restart (restart),
        .limit   (off_timeout),
        .expired (tmo_hit)
    );

    agc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .pwm_req    (pwm_req),
        .hs_off_fb  (hs_off_fb),
        .ls_off_fb  (ls_off_fb),
        .tmo_hit    (tmo_hit),
        .state_q    (state_q),
        .state_d    (state_d),
        .hs_cmd     (hs_gate),
        .ls_cmd     (ls_gate),
        .fault_flag (fault)
    );

endmodule

// File: rtl/adaptive_gate_ctrl_chk.sv
module adaptive_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic pwm_req,
    input logic hs_off_fb,
    input logic ls_off_fb,
    input logic hs_gate,
    input logic ls_gate,
    input logic fault
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!hs_gate && !ls_gate && !fault); // R1
        end
    end

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_gate && !ls_gate && !fault)); // R2

    AST_HS_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate && !pwm_req) |=> !hs_gate); // R3

    AST_LS_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_gate && pwm_req) |=> !ls_gate); // R3

    AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_off_fb) && $past(pwm_req) && $past(enable))); // R4

    AST_LS_AFTER_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_off_fb) && !$past(pwm_req) && $past(enable))); // R5

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate)); // R6

    AST_FULL_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_gate && pwm_req && enable) |=> hs_gate); // R7

    AST_FAULT_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_gate && !ls_gate)); // R9

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault); // R9

endmodule

bind adaptive_gate_ctrl adaptive_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pwm_req   (pwm_req),
    .hs_off_fb (hs_off_fb),
    .ls_off_fb (ls_off_fb),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .fault     (fault)
);

// File: tb/tb_adaptive_gate_ctrl.sv
`timescale 1ns/1ps
module tb_adaptive_gate_ctrl;

    localparam int TMO_W = 8;
    localparam int M_IDLE = 0, M_HW = 1, M_HON = 2, M_LW = 3, M_LON = 4, M_FLT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pwm_req = 1'b0;
    logic hs_off_fb = 1'b0;
    logic ls_off_fb = 1'b0;
    logic [TMO_W-1:0] off_timeout = 8'd40;
    logic hs_gate, ls_gate, fault;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int fb_dly = 0;
    bit stuck_hs = 1'b0;
    bit stuck_ls = 1'b0;
    int hs_low_run = 0;
    int ls_low_run = 0;
    int m_st = M_IDLE;
    int m_cnt = 0;

    always #4 clk = ~clk;

    adaptive_gate_ctrl #(.TMO_W(TMO_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .pwm_req     (pwm_req),
        .hs_off_fb   (hs_off_fb),
        .ls_off_fb   (ls_off_fb),
        .off_timeout (off_timeout),
        .hs_gate     (hs_gate),
        .ls_gate     (ls_gate),
        .fault       (fault)
    );

    // Next state of the reference model, from the requirements
    function automatic int model_next(int st, int cnt);
        int nx;
        nx = st;
        if (!enable) return M_IDLE;
        case (st)
            M_IDLE: nx = pwm_req ? M_HW : M_LW;
            M_HW:   if (!pwm_req) nx = M_LW;
                    else if (ls_off_fb) nx = M_HON;
                    else if (cnt == int'(off_timeout)) nx = M_FLT;
            M_HON:  if (!pwm_req) nx = M_LW;
            M_LW:   if (pwm_req) nx = M_HW;
                    else if (hs_off_fb) nx = M_LON;
                    else if (cnt == int'(off_timeout)) nx = M_FLT;
            M_LON:  if (pwm_req) nx = M_HW;
            default: nx = st;
        endcase
        return nx;
    endfunction

    task automatic step_model();
        int nx;
        if (!rst_n) begin
            m_st = M_IDLE;
            m_cnt = 0;
        end else begin
            nx = model_next(m_st, m_cnt);
            if ((m_st == M_HW || m_st == M_LW) && nx == m_st) m_cnt++;
            else m_cnt = 0;
            m_st = nx;
        end
    endtask

    task automatic check_bit(string tag, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", tag, name, $time, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check_bit(tag, "hs_gate", hs_gate, m_st == M_HON);
        check_bit(tag, "ls_gate", ls_gate, m_st == M_LON);
        check_bit(tag, "fault", fault, m_st == M_FLT);
    endtask

    // Gate feedback model: flag rises fb_dly samples after the gate goes low
    task automatic update_fb();
        if (hs_gate) hs_low_run = 0; else hs_low_run++;
        if (ls_gate) ls_low_run = 0; else ls_low_run++;
        hs_off_fb = !stuck_hs && (hs_low_run > fb_dly);
        ls_off_fb = !stuck_ls && (ls_low_run > fb_dly);
    endtask

    task automatic cyc(string tag, logic en, logic pwm);
        enable = en;
        pwm_req = pwm;
        @(posedge clk);
        step_model();
        @(negedge clk);
        check_outputs(tag);
        update_fb();
    endtask

    task automatic random_run(string tag, int n, int max_run, int dis_pct);
        int run = 0;
        logic p = 1'b0;
        logic e = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (run == 0) begin
                p = ~p;
                run = 1 + int'($urandom % max_run);
            end
            run--;
            e = (int'($urandom % 100) >= dis_pct);
            cyc(tag, e, p);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset holds everything low
        for (int i = 0; i < 4; i++) cyc("R1", 1'b1, 1'b1);
        rst_n = 1'b1;

        // R4 R5 R3: start low side, then random PWM with short feedback delays
        for (int i = 0; i < 5; i++) cyc("R5", 1'b1, 1'b0);
        check_bit("R5", "ls_gate on", ls_gate, 1'b1);
        for (int r = 0; r < 6; r++) begin
            fb_dly = int'($urandom % 5);
            random_run("R3 R4 R5", 300, 25, 0);
        end

        // R7: 100% duty with a tiny timeout
        fb_dly = 2;
        off_timeout = 8'd5;
        for (int i = 0; i < 300; i++) cyc("R7", 1'b1, 1'b1);
        check_bit("R7", "hs_gate held", hs_gate, 1'b1);
        check_bit("R7", "no fault", fault, 1'b0);

        // R8: reversals faster than the feedback delay
        fb_dly = 8;
        off_timeout = 8'd60;
        random_run("R8", 500, 6, 0);
        // directed: low side on, brief high request, back to low side
        fb_dly = 1;
        for (int i = 0; i < 10; i++) cyc("R8", 1'b1, 1'b0);
        cyc("R8", 1'b1, 1'b1);
        check_bit("R8", "ls off after flip", ls_gate, 1'b0);
        cyc("R8", 1'b1, 1'b0);
        check_bit("R8", "hs not yet on", hs_gate, 1'b0);
        for (int i = 0; i < 4; i++) cyc("R8", 1'b1, 1'b0);
        check_bit("R8", "ls back on", ls_gate, 1'b1);

        // R9: low-side feedback stuck, high side requested
        stuck_ls = 1'b1;
        off_timeout = 8'd5;
        for (int i = 0; i < 10; i++) cyc("R9", 1'b1, 1'b1);
        check_bit("R9", "fault raised", fault, 1'b1);
        random_run("R9", 40, 4, 0);
        check_bit("R9", "fault sticky", fault, 1'b1);
        cyc("R2", 1'b0, 1'b1);
        check_bit("R2", "fault cleared", fault, 1'b0);
        // zero timeout corner
        off_timeout = 8'd0;
        for (int i = 0; i < 4; i++) cyc("R9", 1'b1, 1'b1);
        check_bit("R9", "zero limit fault", fault, 1'b1);
        cyc("R2", 1'b0, 1'b0);

        // R10: both feedbacks stuck, reversal every 3 cycles against limit 4
        stuck_hs = 1'b1;
        off_timeout = 8'd4;
        for (int k = 0; k < 14; k++) begin
            for (int j = 0; j < 3; j++) cyc("R10", 1'b1, k[0]);
        end
        check_bit("R10", "no fault on reversals", fault, 1'b0);
        for (int i = 0; i < 7; i++) cyc("R10", 1'b1, 1'b1);
        check_bit("R10", "fault after hold", fault, 1'b1);
        stuck_hs = 1'b0;
        stuck_ls = 1'b0;
        cyc("R2", 1'b0, 1'b0);

        // R2: random disables mixed into traffic
        off_timeout = 8'd30;
        for (int r = 0; r < 4; r++) begin
            fb_dly = int'($urandom % 6);
            random_run("R2", 300, 12, 8);
        end
        cyc("R2", 1'b0, 1'b1);
        check_bit("R2", "hs low when disabled", hs_gate, 1'b0);
        check_bit("R2", "ls low when disabled", ls_gate, 1'b0);

        // R1: reset mid-run
        cyc("R1", 1'b1, 1'b1);
        rst_n = 1'b0;
        #1;
        check_bit("R1", "async reset hs", hs_gate, 1'b0);
        check_bit("R1", "async reset fault", fault, 1'b0);
        cyc("R1", 1'b1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule